// File: doc/BRIEF.md
# LED Channel Fault Protection Controller

This block supervises a set of independent LED boost channels (three by default) and decides, every system clock, whether each channel may switch and whether its LED string is connected. It takes digital flags from external comparators: an over-voltage flag, a short-circuit flag, a low-output flag and a dimming input per channel, plus a chip-wide enable and a supply under-voltage flag.

Over-voltage shuts a channel down and holds it there until the enable input is dropped and raised again. A short circuit, once the turn-on blanking window has passed, puts the channel into a hiccup wait. The channel restarts by itself when a parameterised delay has elapsed. Supply under-voltage forces all channels that are not latched off, and the supply is trusted again only after it has stayed good for a set number of cycles. Each channel drives a gate-enable and a disconnect-switch output and reports a 2-bit state. A shared status flag is released whenever any channel reports a low output.

Top module: `led_fault_ctrl`

## Requirements
- R1: An over-voltage flag on a running or hiccuping channel moves it to the latched state (code 2'b11) on the next clock. It stays there, with gate and disconnect outputs low, regardless of other inputs, until `en_i` is low at a clock edge.
- R2: A fault on one channel never changes the state or outputs of any other channel.
- R3: A short-circuit flag is ignored for the first BLANK_CYC clocks after a channel enters the run state. A flag present on a later clock moves it to the hiccup state (code 2'b10) on the next edge.
- R4: A channel stays in the hiccup state for exactly HICCUP_CYC clocks and then returns to run. The count starts again from zero on each new short, and it never wraps.
- R5: `disc_o[i]` is high only while channel i is in run and `dim_i[i]` is high. It follows `dim_i[i]` in the same cycle.
- R6: `flag_o` is high (released) whenever any bit of `low_i` is high, and low otherwise.
- R7: When `uvlo_i` is high, every channel that is not latched is in OFF within two clocks, and latched channels stay latched. The supply is accepted again only after `uvlo_i` has been low for UVLO_REC_CYC consecutive clocks. Channels enter run on the clock after that.
- R8: If the over-voltage and short-circuit flags of a channel are high in the same cycle, the over-voltage response wins.
- R9: The state field `state_o[2i+1:2i]` encodes OFF=2'b00, RUN=2'b01, HICCUP=2'b10, LATCHED=2'b11. Reset puts every channel in OFF with `gate_o` and `disc_o` low.
- R10: With `en_i` low, every channel is OFF on the next clock. With `en_i` high and the supply accepted, an OFF channel enters run on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Chip enable; a low level clears over-voltage latches |
| uvlo_i | input | 1 | Supply under-voltage flag, high when low supply |
| ovp_i | input | N_CH | Per-channel over-voltage comparator flag |
| sc_i | input | N_CH | Per-channel short-circuit comparator flag |
| low_i | input | N_CH | Per-channel output-below-input-sense flag |
| dim_i | input | N_CH | Per-channel dimming input |
| gate_o | output | N_CH | Per-channel switching enable, high in run |
| disc_o | output | N_CH | Per-channel disconnect switch drive, high to connect |
| state_o | output | 2*N_CH | Per-channel state codes, channel i at [2i+1:2i] |
| flag_o | output | 1 | Shared status flag, high means released |

## Verification
A channel stuck in a wrong state shows up on its own `state_o` field and on its gate and disconnect pins one clock after the triggering flag. A failure of isolation shows up as a state change on a neighbour's field in that same cycle. An off-by-one in the blanking or hiccup counter moves the RUN/HICCUP transition by a clock. The bench therefore samples on the exact cycle before and after each expected edge. A latch that clears too early, or an under-voltage filter that accepts the supply too soon, appears as a RUN code one cycle or more ahead of the enable edge or recovery count that should release it.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    CH_OFF    = 2'b00,
    CH_RUN    = 2'b01,
    CH_HICCUP = 2'b10,
    CH_LATCH  = 2'b11
  } ch_state_e;
endpackage

// File: rtl/prot_supply.sv
module prot_supply #(
  parameter int unsigned UVLO_REC_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uvlo_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(UVLO_REC_CYC + 1);
  localparam logic [CW-1:0] REC_LAST = CW'(UVLO_REC_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  // recovery hysteresis: supply must stay good for UVLO_REC_CYC clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (uvlo_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (!ok_q) begin
      if (cnt_q == REC_LAST) ok_q  <= 1'b1;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = ok_q;

  assert_uvlo_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> !ok_o);

  assert_uvlo_rec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(cnt_q) == REC_LAST);
endmodule

// File: rtl/prot_chan.sv
module prot_chan
  import prot_pkg::*;
#(
  parameter int unsigned BLANK_CYC  = 30,
  parameter int unsigned HICCUP_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       supply_ok_i,
  input  logic       ovp_i,
  input  logic       sc_i,
  input  logic       dim_i,
  output logic       gate_o,
  output logic       disc_o,
  output logic [1:0] state_o
);
  localparam int unsigned CNT_MAX = (BLANK_CYC > HICCUP_CYC) ? BLANK_CYC : HICCUP_CYC;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);
  localparam logic [CW-1:0] HIC_LAST  = CW'(HICCUP_CYC - 1);

  ch_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          blank_done;

  assign blank_done = (cnt_q == BLANK_END);

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = CH_OFF;
    end else begin
      unique case (st_q)
        CH_OFF:    if (supply_ok_i) st_d = CH_RUN;
        CH_RUN: begin
          if (ovp_i)                   st_d = CH_LATCH;
          else if (!supply_ok_i)       st_d = CH_OFF;
          else if (sc_i && blank_done) st_d = CH_HICCUP;
        end
        CH_HICCUP: begin
          if (ovp_i)                 st_d = CH_LATCH;
          else if (!supply_ok_i)     st_d = CH_OFF;
          else if (cnt_q == HIC_LAST) st_d = CH_RUN;
        end
        CH_LATCH:  st_d = CH_LATCH;
        default:   st_d = CH_OFF;
      endcase
    end
  end

  // one saturating counter: blanking in run, wait time in hiccup
  always_comb begin
    cnt_d = cnt_q;
    if (st_d != st_q)                                cnt_d = '0;
    else if (st_q == CH_RUN && cnt_q < BLANK_END)    cnt_d = cnt_q + 1'b1;
    else if (st_q == CH_HICCUP && cnt_q < HIC_LAST)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gate_o  = (st_q == CH_RUN);
  assign disc_o  = gate_o && dim_i;
  assign state_o = st_q;

  assert_latch_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_LATCH && en_i) |=> st_q == CH_LATCH);

  assert_ovp_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ovp_i && (st_q == CH_RUN || st_q == CH_HICCUP)) |=> st_q == CH_LATCH);

  assert_blank_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_RUN && cnt_q < BLANK_END && en_i && supply_ok_i && !ovp_i) |=> st_q == CH_RUN);

  assert_hiccup_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_RUN && $past(st_q) == CH_HICCUP) |-> $past(cnt_q) == HIC_LAST);

  assert_disable_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == CH_OFF);
endmodule

// File: rtl/led_fault_ctrl.sv
module led_fault_ctrl #(
  parameter int unsigned N_CH         = 3,
  parameter int unsigned BLANK_CYC    = 30,
  parameter int unsigned HICCUP_CYC   = 200,
  parameter int unsigned UVLO_REC_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              uvlo_i,
  input  logic [N_CH-1:0]   ovp_i,
  input  logic [N_CH-1:0]   sc_i,
  input  logic [N_CH-1:0]   low_i,
  input  logic [N_CH-1:0]   dim_i,
  output logic [N_CH-1:0]   gate_o,
  output logic [N_CH-1:0]   disc_o,
  output logic [2*N_CH-1:0] state_o,
  output logic              flag_o
);
  logic supply_ok;

  prot_supply #(.UVLO_REC_CYC(UVLO_REC_CYC)) u_supply (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uvlo_i (uvlo_i),
    .ok_o   (supply_ok)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    prot_chan #(.BLANK_CYC(BLANK_CYC), .HICCUP_CYC(HICCUP_CYC)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .supply_ok_i (supply_ok),
      .ovp_i       (ovp_i[i]),
      .sc_i        (sc_i[i]),
      .dim_i       (dim_i[i]),
      .gate_o      (gate_o[i]),
      .disc_o      (disc_o[i]),
      .state_o     (state_o[2*i +: 2])
    );
  end

  // released (high) when any output sits below the input-sense level
  assign flag_o = |low_i;

  assert_disc_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disc_o & ~gate_o) == '0);
endmodule

// File: tb/led_fault_ctrl_tb.sv
module led_fault_ctrl_tb;
  localparam int N   = 3;
  localparam int BLK = 30;
  localparam int HIC = 200;
  localparam int REC = 8;

  localparam logic [1:0] S_OFF = 2'b00, S_RUN = 2'b01, S_HIC = 2'b10, S_LAT = 2'b11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, uvlo_i = 1'b0;
  logic [N-1:0] ovp_i = '0, sc_i = '0, low_i = '0, dim_i = '1;
  logic [N-1:0] gate_o, disc_o;
  logic [2*N-1:0] state_o;
  logic flag_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  led_fault_ctrl #(.N_CH(N), .BLANK_CYC(BLK), .HICCUP_CYC(HIC), .UVLO_REC_CYC(REC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .uvlo_i(uvlo_i),
    .ovp_i(ovp_i), .sc_i(sc_i), .low_i(low_i), .dim_i(dim_i),
    .gate_o(gate_o), .disc_o(disc_o), .state_o(state_o), .flag_o(flag_o)
  );

  // {low, dim, exp_flag, exp_disc} with all channels running
  localparam logic [9:0] VEC [8] = '{
    {3'b000, 3'b111, 1'b0, 3'b111},
    {3'b001, 3'b111, 1'b1, 3'b111},
    {3'b010, 3'b101, 1'b1, 3'b101},
    {3'b100, 3'b010, 1'b1, 3'b010},
    {3'b000, 3'b000, 1'b0, 3'b000},
    {3'b111, 3'b110, 1'b1, 3'b110},
    {3'b000, 3'b011, 1'b0, 3'b011},
    {3'b110, 3'b100, 1'b1, 3'b100}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    step(2);
    chk("R9 reset state", 32'(state_o), 32'h0);
    chk("R9 reset outputs", 32'({gate_o, disc_o}), 32'h0);
    rst_ni = 1'b1; en_i = 1'b1;
    step(REC);
    chk("R7 recovery not yet", 32'(state_o), 32'h0);
    step(1);
    chk("R10 enter run", 32'(state_o), {26'h0, S_RUN, S_RUN, S_RUN});

    // vector walk: dimming and status flag
    for (int v = 0; v < 8; v++) begin
      low_i = VEC[v][9:7];
      dim_i = VEC[v][6:4];
      #1;
      chk($sformatf("R6 flag vec%0d", v), 32'(flag_o), 32'(VEC[v][3]));
      chk($sformatf("R5 disc vec%0d", v), 32'(disc_o), 32'(VEC[v][2:0]));
      step(1);
    end
    low_i = '0; dim_i = '1;
    step(BLK + 2);

    // short on channel 0: hiccup timing and isolation
    sc_i[0] = 1'b1;
    step(1);
    sc_i[0] = 1'b0;
    chk("R4 enter hiccup", 32'(state_o[1:0]), 32'(S_HIC));
    chk("R2 neighbours run", 32'(state_o[5:2]), {28'h0, S_RUN, S_RUN});
    chk("R5 disc off in fault", 32'(disc_o), 32'b110);
    step(HIC - 1);
    chk("R4 still hiccup", 32'(state_o[1:0]), 32'(S_HIC));
    step(1);
    chk("R4 restart", 32'(state_o[1:0]), 32'(S_RUN));

    // short held from restart: blanked, then hiccup count restarts
    sc_i[0] = 1'b1;
    step(BLK);
    chk("R3 short blanked", 32'(state_o[1:0]), 32'(S_RUN));
    step(1);
    chk("R3 short after blank", 32'(state_o[1:0]), 32'(S_HIC));
    sc_i[0] = 1'b0;
    step(HIC - 1);
    chk("R4 recount still hiccup", 32'(state_o[1:0]), 32'(S_HIC));
    step(1);
    chk("R4 recount restart", 32'(state_o[1:0]), 32'(S_RUN));

    // over-voltage latch on ch1, priority on ch2
    ovp_i[1] = 1'b1;
    ovp_i[2] = 1'b1; sc_i[2] = 1'b1;
    step(1);
    ovp_i = '0; sc_i = '0;
    chk("R1 latched", 32'(state_o[3:2]), 32'(S_LAT));
    chk("R8 ovp wins", 32'(state_o[5:4]), 32'(S_LAT));
    chk("R2 ch0 unaffected", 32'(state_o[1:0]), 32'(S_RUN));
    chk("R1 outputs off", 32'({gate_o, disc_o}), 32'b001_001);
    step(2 * HIC);
    chk("R1 latch persists", 32'(state_o[3:2]), 32'(S_LAT));

    // under-voltage
    uvlo_i = 1'b1;
    step(2);
    chk("R7 uvlo off", 32'(state_o[1:0]), 32'(S_OFF));
    chk("R7 latch kept", 32'(state_o[5:2]), {28'h0, S_LAT, S_LAT});
    uvlo_i = 1'b0;
    step(REC);
    chk("R7 hysteresis hold", 32'(state_o[1:0]), 32'(S_OFF));
    step(1);
    chk("R7 recover", 32'(state_o[1:0]), 32'(S_RUN));

    // enable cycle clears latch
    en_i = 1'b0;
    step(1);
    chk("R10 disable all off", 32'(state_o), 32'h0);
    en_i = 1'b1;
    step(1);
    chk("R1 cleared by enable cycle", 32'(state_o), {26'h0, S_RUN, S_RUN, S_RUN});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule